// File: doc/BRIEF.md
# Quadword Aligned Load/Store Sequencer

This block carries out 128-bit register loads and stores over a memory port that moves 64 bits per beat. A request supplies a base address, a 16-bit signed displacement, a register index, a load/store select and, for stores, the 128-bit source value. The block adds the sign-extended displacement to the base and clears the bottom four bits of the sum, so the access always lands on a 16-byte boundary and is never faulted.

Each accepted request becomes two ordered memory beats: the lower 64 bits at the aligned address, then the upper 64 bits at the aligned address plus 8. A store drives the source halves onto the write-data bus in that order. A load collects both returned beats and presents one 128-bit register-file write in the completion cycle, never a half-updated value. A load that targets register 0 does nothing on the memory side and completes at once.

The memory port is a plain request/acknowledge interface: the block holds a beat on the bus until the acknowledge is sampled high. A new request is taken only while the block is idle, and `busy` covers the whole operation up to and including the single-cycle `done` pulse.

Top module: `qw_ldst_seq`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended from bit 15 to the address width, modulo 2^ADDR_W.
- R2: The first beat uses the effective address with bits [3:0] forced to zero; any alignment of the effective address is accepted without a fault.
- R3: Exactly two beats are issued per memory-touching request, the first at the aligned address and the second at the aligned address plus 8, in that order.
- R4: While `mem_req` is high and `mem_ack` is low, the block keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged on the next cycle.
- R5: For a load to a nonzero register, `rf_we` rises only in the `done` cycle, after both beats were acknowledged, with `rf_waddr` equal to the request's register index and `rf_wdata` equal to {second beat data, first beat data}.
- R6: A load to register 0 issues no memory beat, pulses `done` in the cycle after acceptance and never asserts `rf_we`.
- R7: A store drives `mem_we` high on both beats, puts `req_sdata[63:0]` on the first beat and `req_sdata[127:64]` on the second, and never asserts `rf_we`.
- R8: A store whose register index is 0 still performs both beats, with `mem_wdata` zero on each, whatever `req_sdata` holds.
- R9: A request is accepted only on a clock edge where `busy` is low and `req_valid` is high; `req_valid` and the request fields are ignored while `busy` is high. `busy` is high from the cycle after acceptance through the `done` cycle and low in the cycle after it.
- R10: `done` is a one-cycle pulse, given once per accepted request.
- R11: During and after reset `busy`, `mem_req`, `mem_we`, `done` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | OFFS_W | Signed displacement |
| req_reg | input | REG_IDX_W | Destination (load) or source (store) register index |
| req_sdata | input | 2*BEAT_W | Store source value as read from the register file |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | BEAT_W | Beat write data |
| mem_ack | input | 1 | Memory accepted/completed the beat this cycle |
| mem_rdata | input | BEAT_W | Read data, valid with `mem_ack` |
| rf_we | output | 1 | 128-bit register write strobe |
| rf_waddr | output | REG_IDX_W | Register write index |
| rf_wdata | output | 2*BEAT_W | Assembled load value |
| done | output | 1 | Completion pulse |

## Verification
The hardest situation to reach from the ports is a new request arriving while a stalled beat is still outstanding, with different fields than the one in flight: it must neither disturb the held address and data nor start a second operation. The memory model stalls each beat for a random number of cycles and puts garbage on `mem_rdata` while not acknowledging, and on many transactions the stimulus keeps `req_valid` high with fresh random fields for the whole operation, then checks that `busy` falls and no beat appears after `done`. Directed cases cover displacement sign extension and address wrap, register 0 on both load and store, and misaligned bases.

// File: rtl/qw_ldst_pkg.sv
// Shared types for the quadword load/store sequencer.
package qw_ldst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } qw_state_e;
endpackage

// File: rtl/qw_addr_gen.sv
// Effective address former. Adds the sign-extended displacement to the
// base and clears the low ALIGN_BITS bits. Purely combinational.
// Assumes OFFS_W < ADDR_W and ALIGN_BITS < ADDR_W.
module qw_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int OFFS_W     = 16,
    parameter int ALIGN_BITS = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFFS_W-1:0] offset,
    output logic [ADDR_W-1:0] aligned_addr
);
    localparam int EXT_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] eff_addr;

    // Sign extension, add and alignment mask.
    always_comb begin
        off_ext      = {{EXT_W{offset[OFFS_W-1]}}, offset};
        eff_addr     = base + off_ext;
        aligned_addr = {eff_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
endmodule

// File: rtl/qw_beat_fsm.sv
// Beat sequencer. Walks IDLE -> LO -> HI -> DONE for a memory-touching
// request, or IDLE -> DONE for a load to register 0. Each beat state is
// held until mem_ack is sampled high. Assumes the memory side never
// acknowledges without mem_req.
module qw_beat_fsm
    import qw_ldst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_store,
    input  logic req_reg_zero,
    input  logic op_store,
    input  logic mem_ack,
    output logic accept,
    output logic mem_req,
    output logic sel_hi,
    output logic cap_lo,
    output logic cap_hi,
    output logic busy,
    output logic done
);
    qw_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        accept  = (state_q == ST_IDLE) && req_valid;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (!req_store && req_reg_zero) ? ST_DONE : ST_LO;
            ST_LO:   if (mem_ack) state_d = ST_HI;
            ST_HI:   if (mem_ack) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the current state.
    always_comb begin
        mem_req = (state_q == ST_LO) || (state_q == ST_HI);
        sel_hi  = (state_q == ST_HI);
        cap_lo  = (state_q == ST_LO) && mem_ack && !op_store;
        cap_hi  = (state_q == ST_HI) && mem_ack && !op_store;
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
    end

    // R4: an unacknowledged beat stays on the bus.
    a_r4_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(sel_hi)));

    // R3: the upper beat is entered only from an acknowledged lower beat.
    a_r3_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_hi) |-> ($past(state_q) == ST_LO && $past(mem_ack)));

    // R10: completion lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy only drops right after a completion.
    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

// File: rtl/qw_xfer_regs.sv
// Transfer datapath. Latches the aligned address, kind and register index
// at acceptance, and keeps one 128-bit buffer that holds the store source
// (zeroed for register 0) or collects the two load beats.
module qw_xfer_regs #(
    parameter int ADDR_W    = 32,
    parameter int REG_IDX_W = 5,
    parameter int BEAT_W    = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  req_store,
    input  logic [REG_IDX_W-1:0]  req_reg,
    input  logic [2*BEAT_W-1:0]   req_sdata,
    input  logic [ADDR_W-1:0]     aligned_addr,
    input  logic                  cap_lo,
    input  logic                  cap_hi,
    input  logic                  sel_hi,
    input  logic                  mem_req,
    input  logic                  mem_ack,
    input  logic [BEAT_W-1:0]     mem_rdata,
    output logic                  op_store,
    output logic [REG_IDX_W-1:0]  op_reg,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [BEAT_W-1:0]     mem_wdata,
    output logic [2*BEAT_W-1:0]   qw_buf
);
    localparam int HALF_BYTES = BEAT_W / 8;

    logic [ADDR_W-1:0] addr_q;

    // Request capture and beat collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            op_store <= 1'b0;
            op_reg   <= '0;
            qw_buf   <= '0;
        end else if (accept) begin
            addr_q   <= aligned_addr;
            op_store <= req_store;
            op_reg   <= req_reg;
            qw_buf   <= (req_reg == '0) ? '0 : req_sdata;
        end else begin
            if (cap_lo) qw_buf[BEAT_W-1:0]        <= mem_rdata;
            if (cap_hi) qw_buf[2*BEAT_W-1:BEAT_W] <= mem_rdata;
        end
    end

    // Beat address and write-data selection.
    always_comb begin
        mem_addr  = addr_q + (sel_hi ? ADDR_W'(HALF_BYTES) : '0);
        mem_wdata = sel_hi ? qw_buf[2*BEAT_W-1:BEAT_W] : qw_buf[BEAT_W-1:0];
    end

    // R2: every beat address is 8-byte aligned, bit 3 tells the half.
    a_r2_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000 && mem_addr[3] == sel_hi));

    // R4: address and data held while the beat waits.
    a_r4_addr_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/qw_ldst_seq.sv
// Quadword load/store sequencer top. Splits one 128-bit register transfer
// into two ordered 64-bit beats at a 16-byte aligned address and returns
// a single register-file write for loads. Assumes the register file
// supplies req_sdata in the acceptance cycle.
module qw_ldst_seq #(
    parameter int ADDR_W    = 32,
    parameter int OFFS_W    = 16,
    parameter int REG_IDX_W = 5,
    parameter int BEAT_W    = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_store,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [OFFS_W-1:0]    req_offset,
    input  logic [REG_IDX_W-1:0] req_reg,
    input  logic [2*BEAT_W-1:0]  req_sdata,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BEAT_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [BEAT_W-1:0]    mem_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [2*BEAT_W-1:0]  rf_wdata,
    output logic                 done
);
    localparam int ALIGN_BITS = $clog2(2 * BEAT_W / 8);

    logic                 accept, sel_hi, cap_lo, cap_hi, op_store;
    logic [REG_IDX_W-1:0] op_reg;
    logic [ADDR_W-1:0]    aligned_addr;
    logic [2*BEAT_W-1:0]  qw_buf;

    qw_addr_gen #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_addr (
        .base(req_base), .offset(req_offset), .aligned_addr(aligned_addr)
    );

    qw_beat_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_reg_zero(req_reg == '0), .op_store(op_store), .mem_ack(mem_ack),
        .accept(accept), .mem_req(mem_req), .sel_hi(sel_hi), .cap_lo(cap_lo),
        .cap_hi(cap_hi), .busy(busy), .done(done)
    );

    qw_xfer_regs #(
        .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W), .BEAT_W(BEAT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_store(req_store),
        .req_reg(req_reg), .req_sdata(req_sdata), .aligned_addr(aligned_addr),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .sel_hi(sel_hi), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .op_store(op_store),
        .op_reg(op_reg), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .qw_buf(qw_buf)
    );

    // Register-file write and write-enable qualification.
    always_comb begin
        mem_we   = mem_req && op_store;
        rf_we    = done && !op_store && (op_reg != '0);
        rf_waddr = op_reg;
        rf_wdata = qw_buf;
    end

    // R5: the register write never happens outside completion.
    a_r5_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done);

    // R7: a store never writes the register file.
    a_r7_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);
endmodule

// File: tb/tb_qw_ldst_seq.sv
module tb_qw_ldst_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_store = 1'b0;
    logic [31:0]  req_base = '0;
    logic [15:0]  req_offset = '0;
    logic [4:0]   req_reg = '0;
    logic [127:0] req_sdata = '0;
    logic         busy, mem_req, mem_we, rf_we, done;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [63:0]  mem_rdata = '0;
    logic [4:0]   rf_waddr;
    logic [127:0] rf_wdata;

    int checks = 0;
    int failures = 0;
    int seed_dummy;

    qw_ldst_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_base(req_base), .req_offset(req_offset), .req_reg(req_reg),
        .req_sdata(req_sdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_aligned(input logic [31:0] b, input logic [15:0] o);
        logic [31:0] s;
        s = b + {{16{o[15]}}, o};
        return s & 32'hFFFF_FFF0;
    endfunction

    task automatic run_txn(input bit st, input logic [31:0] b, input logic [15:0] o,
                           input logic [4:0] r, input logic [127:0] sd, input bit junk);
        logic [31:0]  al;
        logic [63:0]  lo, hi, ew;
        int           exp_beats, beat;
        bit           seen_done;
        al = exp_aligned(b, o);
        lo = {$urandom, $urandom};
        hi = {$urandom, $urandom};
        exp_beats = (!st && r == 0) ? 0 : 2;
        beat = 0;
        seen_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_base = b; req_offset = o;
        req_reg = r; req_sdata = sd; mem_ack = 1'b0;
        @(negedge clk);
        if (junk) begin
            req_valid = 1'b1; req_store = ~st; req_base = $urandom;
            req_offset = 16'($urandom); req_reg = 5'($urandom);
            req_sdata = {$urandom, $urandom, $urandom, $urandom};
        end else begin
            req_valid = 1'b0;
        end
        chk(busy == 1'b1, "R9 busy after accept", 128'(busy), 128'd1);
        for (int i = 0; i < 64 && !seen_done; i++) begin
            mem_ack = 1'b0;
            mem_rdata = {$urandom, $urandom};
            if (rf_we && !done) chk(1'b0, "R5 rf_we outside done", 128'(rf_we), 128'd0);
            if (done) begin
                seen_done = 1'b1;
                req_valid = 1'b0;
                chk(beat == exp_beats, "R3/R6 beat count", 128'(beat), 128'(exp_beats));
                chk(mem_req == 1'b0, "R10 no beat at done", 128'(mem_req), 128'd0);
                chk(busy == 1'b1, "R9 busy in done cycle", 128'(busy), 128'd1);
                if (!st && r != 0) begin
                    chk(rf_we == 1'b1, "R5 rf_we", 128'(rf_we), 128'd1);
                    chk(rf_waddr == r, "R5 rf_waddr", 128'(rf_waddr), 128'(r));
                    chk(rf_wdata == {hi, lo}, "R5 rf_wdata", rf_wdata, {hi, lo});
                end else begin
                    chk(rf_we == 1'b0, "R6/R7 no rf write", 128'(rf_we), 128'd0);
                end
            end else if (mem_req) begin
                chk(mem_addr == al + (beat != 0 ? 32'd8 : 32'd0), "R1/R2/R3 beat address",
                    128'(mem_addr), 128'(al + (beat != 0 ? 32'd8 : 32'd0)));
                chk(mem_we == st, "R7 mem_we", 128'(mem_we), 128'(st));
                if (st) begin
                    ew = (r == 0) ? 64'd0 : (beat != 0 ? sd[127:64] : sd[63:0]);
                    chk(mem_wdata == ew, "R7/R8 store data", 128'(mem_wdata), 128'(ew));
                end
                if (beat >= 2) chk(1'b0, "R3 extra beat", 128'(beat), 128'd2);
                if (($urandom % 3) != 0) begin
                    mem_ack = 1'b1;
                    mem_rdata = (beat != 0) ? hi : lo;
                    beat++;
                end
            end
            @(negedge clk);
        end
        if (!seen_done) chk(1'b0, "R10 done never seen", 128'd0, 128'd1);
        chk(busy == 1'b0, "R9 busy after done", 128'(busy), 128'd0);
        chk(done == 1'b0, "R10 done one cycle", 128'(done), 128'd0);
        chk(mem_req == 1'b0, "R9 junk request ignored", 128'(mem_req), 128'd0);
        mem_ack = 1'b0;
    endtask

    initial begin
        seed_dummy = $urandom(32'd2024);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!busy && !mem_req && !mem_we && !done && !rf_we, "R11 reset outputs",
                {123'd0, busy, mem_req, mem_we, done, rf_we}, 128'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R11 idle after reset",
            {125'd0, busy, mem_req, done}, 128'd0);
        // Directed corner cases.
        run_txn(1'b0, 32'h0000_0000, 16'hFFFF, 5'd3, '0, 1'b0);              // R1 negative offset wraps
        run_txn(1'b1, 32'hFFFF_FFF8, 16'h0010, 5'd7, {4{32'hA5A5_5A5A}}, 1'b0); // R1 address wrap
        run_txn(1'b1, 32'h1234_567F, 16'h7FFF, 5'd0, {4{32'hFFFF_FFFF}}, 1'b0); // R8 store from reg 0
        run_txn(1'b0, 32'h0000_1009, 16'h0003, 5'd0, '0, 1'b1);              // R6 load to reg 0
        run_txn(1'b0, 32'h8000_000D, 16'h8000, 5'd31, '0, 1'b1);             // R2 misaligned, R9 junk
        run_txn(1'b1, 32'h0000_0100, 16'h0008, 5'd1,
                128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1);         // R7 half order
        // Random mix.
        for (int n = 0; n < 300; n++) begin
            run_txn(1'($urandom), $urandom, 16'($urandom),
                    (($urandom % 6) == 0) ? 5'd0 : 5'($urandom),
                    {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule